// File: doc/BRIEF.md
# Indexed Port Strobe Decoder

This block gives a small I/O bus indirect access to a bank of registers. Software first writes a select byte to an index port. A later read or write on a shared data port then lands on one register. The block does the landing by pulling exactly one active-low strobe low, for as long as the data-port access lasts.

There are 24 write strobes. They cover select values 0xE0 to 0xF7 in three groups of eight. Each group is enabled by the upper five bits of the select byte, and the lower three bits pick one member of the group. There are 5 read strobes, which cover select values 0xE0 to 0xE4. Host address comparison, the strobed registers and data bus driving stay outside the block.

The select register has no system clock. It loads on the falling edge of the active-low index-write input, and the asynchronous reset clears it. All strobes are combinational from the register contents and the access inputs.

Top module: `idx_strobe_top`

## Requirements
- R1: The select register captures `data_i` on the falling edge of `idx_wr_ni`. A change of `data_i` while `idx_wr_ni` is low, or on its rising edge, does not alter the captured value.
- R2: When `rst_ni` is low, the select register is cleared to 0x00. After reset, data-port accesses fire no strobe until a new select byte is written.
- R3: With `rst_ni` high, `wr_ni` low and `rd_ni` high, a select value S in 0xE0..0xF7 drives `wstb_no[S-0xE0]` low. Select bits [7:3] of 11100, 11101 and 11110 map to bit ranges [7:0], [15:8] and [23:16]. Select bits [2:0] pick the bit within the range.
- R4: With `rst_ni` high, `rd_ni` low and `wr_ni` high, a select value S in 0xE0..0xE4 drives `rstb_no[S-0xE0]` low.
- R5: A read with select 0xE5..0xE7, or with any select outside 0xE0..0xE4, fires no strobe. A read never fires a write strobe, and a write never fires a read strobe.
- R6: A write with select outside 0xE0..0xF7 fires no strobe.
- R7: While `rst_ni` is low, every strobe is high, whatever the other inputs are.
- R8: When `rd_ni` and `wr_ni` are both low, every strobe is high.
- R9: At most one strobe of all 29 is low at any time.
- R10: Strobes are combinational. A strobe is low only while its access input is low and returns high as soon as that input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low; clears select, blocks strobes |
| idx_wr_ni | input | 1 | Index-port write, active low; falling edge loads select |
| rd_ni | input | 1 | Data-port read, active low |
| wr_ni | input | 1 | Data-port write, active low |
| data_i | input | 8 | Select byte presented on index writes |
| wstb_no | output | 24 | Write strobes, active low, bit n for select 0xE0+n |
| rstb_no | output | 5 | Read strobes, active low, bit n for select 0xE0+n |

## Verification
Two events can fall in the same cycle. A data-port read can coincide with a data-port write, and a data-port access can coincide with reset. The random loop provokes both by drawing the access kind from write, read, both and neither, and by pulling reset low during about one access in sixteen. Each such case is judged at the outputs: all 29 strobes must stay high. After a reset hit, the bench model clears its select copy, so the next accesses must also stay silent until a new index write.

// File: rtl/idx_strobe_pkg.sv
package idx_strobe_pkg;
  localparam int SEL_W  = 8;
  localparam int LOW_W  = 3;
  localparam int HI_W   = SEL_W - LOW_W;
  localparam int GRP_SZ = 1 << LOW_W;
endpackage

// File: rtl/idx_sel_reg.sv
module idx_sel_reg #(
  parameter int W = 8
) (
  input  logic         rst_ni,
  input  logic         load_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // load on falling edge of active-low strobe (rising edge of its inverse)
  always_ff @(negedge load_ni or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/idx_onehot_dec.sv
module idx_onehot_dec #(
  parameter int CW  = 3,
  parameter int OUT = 8
) (
  input  logic          en_i,
  input  logic [CW-1:0] code_i,
  output logic [OUT-1:0] sel_no
);
  always_comb begin
    for (int i = 0; i < OUT; i++) begin
      sel_no[i] = !(en_i && (code_i == CW'(i)));
    end
  end
endmodule

// File: rtl/idx_strobe_top.sv
module idx_strobe_top
  import idx_strobe_pkg::*;
#(
  parameter int             NUM_WGRP = 3,
  parameter int             RD_NUM   = 5,
  parameter logic [HI_W-1:0] WBASE   = 5'b11100,
  parameter logic [HI_W-1:0] RBASE   = 5'b11100,
  localparam int            WSTB_W   = NUM_WGRP * GRP_SZ
) (
  input  logic              rst_ni,
  input  logic              idx_wr_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [SEL_W-1:0]  data_i,
  output logic [WSTB_W-1:0] wstb_no,
  output logic [RD_NUM-1:0] rstb_no
);
  logic [SEL_W-1:0] sel_q;
  logic [HI_W-1:0]  sel_hi;
  logic [LOW_W-1:0] sel_lo;
  logic             wr_go, rd_go;

  idx_sel_reg #(.W(SEL_W)) u_sel (
    .rst_ni (rst_ni),
    .load_ni(idx_wr_ni),
    .d_i    (data_i),
    .q_o    (sel_q)
  );

  assign sel_hi = sel_q[SEL_W-1:LOW_W];
  assign sel_lo = sel_q[LOW_W-1:0];

  // simultaneous read and write cancel each other
  assign wr_go = rst_ni && !wr_ni && rd_ni;
  assign rd_go = rst_ni && !rd_ni && wr_ni;

  for (genvar g = 0; g < NUM_WGRP; g++) begin : g_wgrp
    localparam logic [HI_W-1:0] GID = HI_W'(int'(WBASE) + g);
    logic grp_en;
    assign grp_en = wr_go && (sel_hi == GID);
    idx_onehot_dec #(.CW(LOW_W), .OUT(GRP_SZ)) u_dec (
      .en_i  (grp_en),
      .code_i(sel_lo),
      .sel_no(wstb_no[g*GRP_SZ +: GRP_SZ])
    );
  end

  logic rd_en;
  assign rd_en = rd_go && (sel_hi == RBASE);

  idx_onehot_dec #(.CW(LOW_W), .OUT(RD_NUM)) u_rdec (
    .en_i  (rd_en),
    .code_i(sel_lo),
    .sel_no(rstb_no)
  );

  always_comb begin
    // R9
    one_strobe_chk: assert ($countones(~{wstb_no, rstb_no}) <= 1)
      else $error("more than one strobe low");
    // R7
    if (!rst_ni) begin
      rst_quiet_chk: assert (&{wstb_no, rstb_no})
        else $error("strobe during reset");
    end
    // R8
    if (!rd_ni && !wr_ni) begin
      clash_quiet_chk: assert (&{wstb_no, rstb_no})
        else $error("strobe on read/write clash");
    end
    // R10
    if (rd_ni && wr_ni) begin
      idle_quiet_chk: assert (&{wstb_no, rstb_no})
        else $error("strobe with no access");
    end
    // R5
    if (!rd_ni) begin
      rd_no_wstb_chk: assert (&wstb_no)
        else $error("write strobe on read");
    end
  end
endmodule

// File: tb/idx_strobe_top_tb_top.sv
`timescale 1ns/1ps
module idx_strobe_top_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_ni = 1'b0, idx_wr_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0]  data_i = 8'h00;
  logic [23:0] wstb_no;
  logic [4:0]  rstb_no;

  idx_strobe_top dut_i (
    .rst_ni(rst_ni), .idx_wr_ni(idx_wr_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .data_i(data_i), .wstb_no(wstb_no), .rstb_no(rstb_no)
  );

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [7:0] sel_m = 8'h00;

  function automatic logic [23:0] exp_w(logic [7:0] s, logic rs_n, logic rd_n, logic wr_n);
    logic [23:0] w = '1;
    if (rs_n && !wr_n && rd_n && s >= 8'hE0 && s <= 8'hF7) w[s - 8'hE0] = 1'b0;
    return w;
  endfunction

  function automatic logic [4:0] exp_r(logic [7:0] s, logic rs_n, logic rd_n, logic wr_n);
    logic [4:0] r = '1;
    if (rs_n && !rd_n && wr_n && s >= 8'hE0 && s <= 8'hE4) r[s - 8'hE0] = 1'b0;
    return r;
  endfunction

  task automatic check(string tag);
    logic [23:0] ew = exp_w(sel_m, rst_ni, rd_ni, wr_ni);
    logic [4:0]  er = exp_r(sel_m, rst_ni, rd_ni, wr_ni);
    total++;
    if (wstb_no !== ew || rstb_no !== er) begin
      bad++;
      $display("FAIL %s: sel=%h wstb=%h rstb=%h expected wstb=%h rstb=%h",
               tag, sel_m, wstb_no, rstb_no, ew, er);
    end
  endtask

  task automatic idx_write(logic [7:0] v);
    data_i = v; #1;
    idx_wr_ni = 1'b0; sel_m = v; #1;
    data_i = 8'($urandom); #1;
    idx_wr_ni = 1'b1; #1;
    data_i = 8'($urandom); #1;
  endtask

  task automatic access(logic r_n, logic w_n, string tag);
    rd_ni = r_n; wr_ni = w_n; #1;
    check(tag);
    rd_ni = 1'b1; wr_ni = 1'b1; #1;
    check({tag, " release R10"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: expired, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    #3;
    check("R2 reset state");
    // R7: access during reset
    wr_ni = 1'b0; #1; check("R7 write in reset"); wr_ni = 1'b1;
    rst_ni = 1'b1; #2;
    // R2: select is 0x00 after reset
    access(1'b1, 1'b0, "R2 write after reset");
    // R3: every write index, group boundaries
    for (int i = 8'hE0; i <= 8'hF7; i++) begin
      idx_write(8'(i));
      access(1'b1, 1'b0, "R3 write map");
    end
    // R4 / R5: read map including 0xE5..0xE7
    for (int i = 8'hE0; i <= 8'hE8; i++) begin
      idx_write(8'(i));
      access(1'b0, 1'b1, "R4 R5 read map");
    end
    // R6: just outside the window
    idx_write(8'hDF); access(1'b1, 1'b0, "R6 below window");
    idx_write(8'hF8); access(1'b1, 1'b0, "R6 above window");
    idx_write(8'hF0); access(1'b0, 1'b1, "R5 read high group");
    // R1: value changed while index low is not taken
    data_i = 8'hE2; #1; idx_wr_ni = 1'b0; sel_m = 8'hE2; #1;
    data_i = 8'hF5; #1; idx_wr_ni = 1'b1; #1;
    access(1'b1, 1'b0, "R1 falling-edge capture");
    // R8: clash
    access(1'b0, 1'b0, "R8 read+write clash");
    // R7 then R2: reset mid access clears select
    wr_ni = 1'b0; #1; check("R3 before reset");
    rst_ni = 1'b0; sel_m = 8'h00; #1; check("R7 reset mid write");
    wr_ni = 1'b1; rst_ni = 1'b1; #1;
    access(1'b1, 1'b0, "R2 select cleared");
    // random mix, R9 covered by assertion and exact compare
    for (int n = 0; n < 400; n++) begin
      logic [7:0] s;
      int m;
      s = ($urandom % 4 != 0) ? 8'(8'hD8 + $urandom % 40) : 8'($urandom);
      idx_write(s);
      m = int'($urandom % 4);
      if ($urandom % 16 == 0) begin
        rst_ni = 1'b0; sel_m = 8'h00; #1;
      end
      access(m[0], m[1], "R9 random");
      rst_ni = 1'b1; #1;
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule